// File: doc/BRIEF.md
# Split-Transaction Pending Request Tracker

This block keeps, inside one cache controller, a record of every transaction that is in flight on a split-transaction snooping bus. The bus hands each winning request a small tag. Every controller watches the request bus and fills the slot whose index equals that tag, so all copies of the table agree on slot numbering. When a response carrying a tag shows up on the response bus, the slot with that index is freed and the bus may reuse the tag. Writebacks and upgrades never get a data response, so they take no slot.

The processor side asks the table about a miss before the miss goes out. A lookup compares the block address against all live slots at once. The answer is one of three. The miss may issue. It may piggyback on a pending read of the same block, in which case the slot remembers to grab the data and the controller drives the shared snoop line so that other receivers fill in Shared. Or it must wait until an incompatible pending transaction retires. A second allocation onto a live slot is a protocol error, which is flagged for one cycle; the new request then overwrites the slot.

Bus monitoring inputs carry a valid qualifier and no ready. A snooping bus cannot be stalled by an observer, so every qualified beat is taken in the cycle it appears. Lookup and response answers are combinational within the same cycle. Table updates take effect at the next clock edge.

Top module: `txn_tracker`

## Requirements
- R1: After reset no slot is live. Every lookup answers issue, no response matches, the shared request is low and the error flag is low.
- R2: A request-bus beat with kind 0 (read) or kind 1 (read-exclusive) fills the slot indexed by its tag with its address, kind and origin bit. From the next cycle, lookups and responses see that slot.
- R3: A request-bus beat with kind 2 (upgrade) or kind 3 (writeback) changes no slot and never raises the error flag.
- R4: A response beat whose tag names a live slot reports a hit, together with that slot's origin and grab bits, and frees the slot at the clock edge. A response beat that names a free slot reports no hit. With no response beat, all response outputs are low.
- R5: A non-exclusive lookup that matches only live read slots answers grab and not issue, and it sets the grab bit of every matching slot at the next edge.
- R6: The shared request is high exactly while some live slot has its grab bit set and its origin bit clear.
- R7: A lookup answers wait when it matches a live read-exclusive slot, or when it is exclusive and matches any live slot. At most one of issue, grab and wait is high, and exactly one is high while a lookup is valid.
- R8: An allocating beat onto a live slot that is not retired in the same cycle raises the error flag for exactly the next cycle. The slot takes the new request's fields, with its grab and state cleared.
- R9: A state beat for a live slot stores this cache's state for the block. A response to that slot then reports the state as known and gives its value. An allocation clears the known state.
- R10: A response and an allocation to the same tag in one cycle leave the slot live with the new request, and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_valid | input | 1 | Request-bus beat present |
| rq_tag | input | TAG_W | Tag assigned to the request |
| rq_addr | input | ADDR_W | Block address of the request |
| rq_kind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 writeback |
| rq_mine | input | 1 | Request was issued by this controller |
| rs_valid | input | 1 | Response-bus beat present |
| rs_tag | input | TAG_W | Tag carried by the response |
| st_valid | input | 1 | Snoop-state beat present |
| st_tag | input | TAG_W | Slot whose state is reported |
| st_state | input | STATE_W | This cache's state for the block |
| lk_valid | input | 1 | Processor lookup present |
| lk_addr | input | ADDR_W | Block address of the miss |
| lk_excl | input | 1 | Miss needs exclusive ownership |
| lk_issue | output | 1 | Miss may issue a new request |
| lk_grab | output | 1 | Miss piggybacks on a pending read |
| lk_wait | output | 1 | Miss must retry after a conflicting slot retires |
| rs_hit | output | 1 | Response names a live slot |
| rs_own | output | 1 | That slot was issued by this controller |
| rs_grab | output | 1 | This controller must capture the response data |
| rs_known | output | 1 | Slot holds a known snoop state |
| rs_state | output | STATE_W | Stored snoop state (zero when unknown) |
| sh_assert | output | 1 | Drive the shared snoop line |
| dup_err | output | 1 | Allocation landed on a live slot (one-cycle pulse) |

## Verification
A wrong slot bit in this block shows up at the ports on the first lookup or response that touches the slot. A slot that is stuck live turns a later issue into wait or grab. A slot that is lost turns a wait into issue. A grab bit that is never set keeps the shared request low and clears the data capture on the response. Because every slot is visible through a lookup in the cycle after it changes, the bench model compares all outputs on every clock. A corruption therefore shows up in the first cycle in which the stimulus addresses the affected slot.

// File: rtl/txn_pkg.sv
package txn_pkg;
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_READX = 2'd1,
    K_UPGR  = 2'd2,
    K_WBACK = 2'd3
  } kind_e;

  function automatic logic kind_takes_slot(kind_e k);
    return (k == K_READ) || (k == K_READX);
  endfunction
endpackage

// File: rtl/txn_entry.sv
module txn_entry
  import txn_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  kind_e              alloc_kind,
  input  logic               alloc_mine,
  input  logic               retire,
  input  logic               grab_set,
  input  logic               st_set,
  input  logic [STATE_W-1:0] st_val,
  output logic               valid,
  output logic [ADDR_W-1:0]  addr,
  output kind_e              kind,
  output logic               mine,
  output logic               grab,
  output logic               known,
  output logic [STATE_W-1:0] state,
  output logic               dup
);
  // an allocation onto a live slot is only legal when the slot retires now
  assign dup = alloc && valid && !retire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      kind  <= K_READ;
      mine  <= 1'b0;
      grab  <= 1'b0;
      known <= 1'b0;
      state <= '0;
    end else if (alloc) begin
      valid <= 1'b1;
      addr  <= alloc_addr;
      kind  <= alloc_kind;
      mine  <= alloc_mine;
      grab  <= 1'b0;
      known <= 1'b0;
      state <= '0;
    end else if (retire) begin
      valid <= 1'b0;
      grab  <= 1'b0;
      known <= 1'b0;
    end else if (valid) begin
      if (grab_set) grab <= 1'b1;
      if (st_set) begin
        known <= 1'b1;
        state <= st_val;
      end
    end
  end
endmodule

// File: rtl/txn_match.sv
module txn_match #(
  parameter int N      = 8,
  parameter int ADDR_W = 32
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][ADDR_W-1:0] addr,
  input  logic [N-1:0]             excl_kind,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic                     lk_excl,
  output logic [N-1:0]             hit_vec,
  output logic                     lk_issue,
  output logic                     lk_grab,
  output logic                     lk_wait
);
  logic any_hit, clash;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && (addr[i] == lk_addr);
  end

  assign any_hit  = |hit_vec;
  assign clash    = (|(hit_vec & excl_kind)) || (lk_excl && any_hit);
  assign lk_issue = lk_valid && !any_hit;
  assign lk_wait  = lk_valid && clash;
  assign lk_grab  = lk_valid && any_hit && !clash;
endmodule

// File: rtl/txn_resp.sv
module txn_resp #(
  parameter int TAG_W   = 3,
  parameter int STATE_W = 2,
  parameter int N       = 1 << TAG_W
) (
  input  logic                      rs_valid,
  input  logic [TAG_W-1:0]          rs_tag,
  input  logic [N-1:0]              valid,
  input  logic [N-1:0]              mine,
  input  logic [N-1:0]              grab,
  input  logic [N-1:0]              known,
  input  logic [N-1:0][STATE_W-1:0] state,
  output logic [N-1:0]              retire,
  output logic                      rs_hit,
  output logic                      rs_own,
  output logic                      rs_grab,
  output logic                      rs_known,
  output logic [STATE_W-1:0]        rs_state
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign retire[i] = rs_valid && (rs_tag == TAG_W'(i));
  end

  assign rs_hit   = rs_valid && valid[rs_tag];
  assign rs_own   = rs_hit && mine[rs_tag];
  assign rs_grab  = rs_hit && grab[rs_tag];
  assign rs_known = rs_hit && known[rs_tag];
  assign rs_state = rs_known ? state[rs_tag] : '0;
endmodule

// File: rtl/txn_tracker.sv
module txn_tracker
  import txn_pkg::*;
#(
  parameter int TAG_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rq_valid,
  input  logic [TAG_W-1:0]   rq_tag,
  input  logic [ADDR_W-1:0]  rq_addr,
  input  logic [1:0]         rq_kind,
  input  logic               rq_mine,
  input  logic               rs_valid,
  input  logic [TAG_W-1:0]   rs_tag,
  input  logic               st_valid,
  input  logic [TAG_W-1:0]   st_tag,
  input  logic [STATE_W-1:0] st_state,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  input  logic               lk_excl,
  output logic               lk_issue,
  output logic               lk_grab,
  output logic               lk_wait,
  output logic               rs_hit,
  output logic               rs_own,
  output logic               rs_grab,
  output logic               rs_known,
  output logic [STATE_W-1:0] rs_state,
  output logic               sh_assert,
  output logic               dup_err
);
  localparam int N = 1 << TAG_W;

  kind_e                    in_kind;
  logic                     takes_slot;
  logic [N-1:0]             e_valid, e_mine, e_grab, e_known, e_dup, e_excl;
  logic [N-1:0]             retire, hit_vec;
  logic [N-1:0][ADDR_W-1:0] e_addr;
  logic [N-1:0][STATE_W-1:0] e_state;
  kind_e                    e_kind [N];
  logic                     dup_q;

  assign in_kind    = kind_e'(rq_kind);
  assign takes_slot = rq_valid && kind_takes_slot(in_kind);

  for (genvar i = 0; i < N; i++) begin : g_slot
    txn_entry #(.ADDR_W(ADDR_W), .STATE_W(STATE_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (takes_slot && (rq_tag == TAG_W'(i))),
      .alloc_addr (rq_addr),
      .alloc_kind (in_kind),
      .alloc_mine (rq_mine),
      .retire     (retire[i]),
      .grab_set   (lk_grab && hit_vec[i]),
      .st_set     (st_valid && (st_tag == TAG_W'(i))),
      .st_val     (st_state),
      .valid      (e_valid[i]),
      .addr       (e_addr[i]),
      .kind       (e_kind[i]),
      .mine       (e_mine[i]),
      .grab       (e_grab[i]),
      .known      (e_known[i]),
      .state      (e_state[i]),
      .dup        (e_dup[i])
    );
    assign e_excl[i] = (e_kind[i] == K_READX);
  end

  txn_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .valid     (e_valid),
    .addr      (e_addr),
    .excl_kind (e_excl),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .lk_excl   (lk_excl),
    .hit_vec   (hit_vec),
    .lk_issue  (lk_issue),
    .lk_grab   (lk_grab),
    .lk_wait   (lk_wait)
  );

  txn_resp #(.TAG_W(TAG_W), .STATE_W(STATE_W), .N(N)) u_resp (
    .rs_valid (rs_valid),
    .rs_tag   (rs_tag),
    .valid    (e_valid),
    .mine     (e_mine),
    .grab     (e_grab),
    .known    (e_known),
    .state    (e_state),
    .retire   (retire),
    .rs_hit   (rs_hit),
    .rs_own   (rs_own),
    .rs_grab  (rs_grab),
    .rs_known (rs_known),
    .rs_state (rs_state)
  );

  // a grabbing controller that did not originate the read announces sharing
  assign sh_assert = |(e_valid & e_grab & ~e_mine);

  always_ff @(posedge clk) begin
    if (!rst_n) dup_q <= 1'b0;
    else        dup_q <= |e_dup;
  end
  assign dup_err = dup_q;
endmodule

// File: rtl/txn_tracker_chk.sv
module txn_tracker_chk #(
  parameter int TAG_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int STATE_W = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rq_valid,
  input logic [1:0] rq_kind,
  input logic       rs_valid,
  input logic       lk_valid,
  input logic       lk_excl,
  input logic       lk_issue,
  input logic       lk_grab,
  input logic       lk_wait,
  input logic       rs_hit,
  input logic       rs_own,
  input logic       rs_grab,
  input logic       rs_known,
  input logic       sh_assert,
  input logic       dup_err
);
  p_answer_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_issue, lk_grab, lk_wait}));

  p_answer_needs_lookup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_issue || lk_grab || lk_wait) == lk_valid);

  p_grab_not_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_grab |-> !lk_excl);

  p_resp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !(rs_hit || rs_own || rs_grab || rs_known));

  p_known_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rs_known |-> rs_hit);

  p_no_slot_kinds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && rq_kind[1]) |=> !dup_err);

  p_err_after_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> $past(rq_valid && !rq_kind[1]));

  p_shared_from_grab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_assert) |-> $past(lk_grab));
endmodule

bind txn_tracker txn_tracker_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .STATE_W(STATE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rq_valid  (rq_valid),
  .rq_kind   (rq_kind),
  .rs_valid  (rs_valid),
  .lk_valid  (lk_valid),
  .lk_excl   (lk_excl),
  .lk_issue  (lk_issue),
  .lk_grab   (lk_grab),
  .lk_wait   (lk_wait),
  .rs_hit    (rs_hit),
  .rs_own    (rs_own),
  .rs_grab   (rs_grab),
  .rs_known  (rs_known),
  .sh_assert (sh_assert),
  .dup_err   (dup_err)
);

// File: tb/txn_tracker_bench.sv
module txn_tracker_bench;
  localparam int TAG_W = 3, ADDR_W = 32, STATE_W = 2, N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rq_valid = 0, rq_mine = 0, rs_valid = 0, st_valid = 0, lk_valid = 0, lk_excl = 0;
  logic [TAG_W-1:0] rq_tag = 0, rs_tag = 0, st_tag = 0;
  logic [ADDR_W-1:0] rq_addr = 0, lk_addr = 0;
  logic [1:0] rq_kind = 0;
  logic [STATE_W-1:0] st_state = 0;
  logic lk_issue, lk_grab, lk_wait, rs_hit, rs_own, rs_grab, rs_known, sh_assert, dup_err;
  logic [STATE_W-1:0] rs_state;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txn_tracker #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .STATE_W(STATE_W)) u_txn_tracker (.*);

  // behavioural reference: one record per tag
  bit          m_v [N], m_mine [N], m_grab [N], m_known [N];
  int          m_kind [N];
  logic [31:0] m_addr [N];
  int          m_state [N];
  bit          m_err;

  function automatic void answer(output bit iss, output bit grb, output bit wt);
    bit any = 0, clash = 0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_addr[i] == lk_addr) begin
        any = 1;
        if (m_kind[i] == 1 || lk_excl) clash = 1;
      end
    iss = lk_valid && !any;
    wt  = lk_valid && clash;
    grb = lk_valid && any && !clash;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_v[i] = 0; m_grab[i] = 0; m_known[i] = 0;
      end
      m_err = 0;
    end else begin
      bit iss, grb, wt, e;
      answer(iss, grb, wt);
      e = 0;
      for (int i = 0; i < N; i++) begin
        bit al, rt;
        al = rq_valid && rq_tag == i && rq_kind < 2;
        rt = rs_valid && rs_tag == i;
        if (al && m_v[i] && !rt) e = 1;
        if (al) begin
          m_v[i] = 1; m_addr[i] = rq_addr; m_kind[i] = rq_kind; m_mine[i] = rq_mine;
          m_grab[i] = 0; m_known[i] = 0;
        end else if (rt) begin
          m_v[i] = 0; m_grab[i] = 0; m_known[i] = 0;
        end else if (m_v[i]) begin
          if (grb && m_addr[i] == lk_addr) m_grab[i] = 1;
          if (st_valid && st_tag == i) begin m_known[i] = 1; m_state[i] = st_state; end
        end
      end
      m_err = e;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every output against the model away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit iss, grb, wt, hit, sh;
      int t;
      answer(iss, grb, wt);
      check("R7", "lk_issue", lk_issue, iss);
      check("R5", "lk_grab", lk_grab, grb);
      check("R7", "lk_wait", lk_wait, wt);
      t = rs_tag;
      hit = rs_valid && m_v[t];
      check("R4", "rs_hit", rs_hit, hit);
      check("R4", "rs_own", rs_own, hit && m_mine[t]);
      check("R4", "rs_grab", rs_grab, hit && m_grab[t]);
      check("R9", "rs_known", rs_known, hit && m_known[t]);
      check("R9", "rs_state", rs_state, (hit && m_known[t]) ? m_state[t] : 0);
      sh = 0;
      for (int i = 0; i < N; i++) if (m_v[i] && m_grab[i] && !m_mine[i]) sh = 1;
      check("R6", "sh_assert", sh_assert, sh);
      check("R8", "dup_err", dup_err, m_err);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    rq_valid = 0; rs_valid = 0; st_valid = 0; lk_valid = 0; lk_excl = 0;
  endtask

  task automatic req(int tag, int addr, int kind, bit mine);
    rq_valid = 1; rq_tag = tag; rq_addr = addr; rq_kind = kind; rq_mine = mine;
  endtask

  task automatic look(int addr, bit excl);
    lk_valid = 1; lk_addr = addr; lk_excl = excl;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: empty table answers issue
    look(32'h100, 0); @(negedge clk);
    check("R1", "issue after reset", lk_issue, 1);
    check("R1", "shared after reset", sh_assert, 0);
    tick();
    // R2: read from another controller at tag 3
    req(3, 32'h100, 0, 0); tick();
    look(32'h100, 0); @(negedge clk);
    check("R2", "allocated read seen", lk_grab, 1);
    tick();
    @(negedge clk); check("R6", "shared after grab", sh_assert, 1);
    // R7: read-exclusive at tag 5
    req(5, 32'h200, 1, 1); tick();
    look(32'h200, 0); @(negedge clk); check("R7", "read vs readx", lk_wait, 1); tick();
    look(32'h100, 1); @(negedge clk); check("R7", "excl vs read", lk_wait, 1); tick();
    // R3: upgrade and writeback take no slot, even on a live tag
    req(1, 32'h300, 2, 1); tick();
    req(3, 32'h300, 3, 1); tick();
    look(32'h300, 0); @(negedge clk);
    check("R3", "upgrade/writeback no slot", lk_issue, 1);
    check("R3", "no error", dup_err, 0);
    tick();
    // R9: state then response on tag 3
    st_valid = 1; st_tag = 3; st_state = 2; tick();
    rs_valid = 1; rs_tag = 3; @(negedge clk);
    check("R9", "state value", rs_state, 2);
    check("R4", "grab on response", rs_grab, 1);
    tick();
    look(32'h100, 0); @(negedge clk); check("R4", "retired slot", lk_issue, 1); tick();
    // R8: duplicate allocation on tag 5
    req(5, 32'h400, 1, 0); tick();
    @(negedge clk); check("R8", "dup pulse", dup_err, 1);
    tick();
    @(negedge clk); check("R8", "dup one cycle", dup_err, 0);
    look(32'h200, 0); @(negedge clk); check("R8", "old addr gone", lk_issue, 1); tick();
    // R10: retire and reallocate tag 5 together
    rs_valid = 1; rs_tag = 5; req(5, 32'h500, 0, 1); tick();
    @(negedge clk); check("R10", "no error", dup_err, 0);
    look(32'h500, 0); @(negedge clk); check("R10", "new slot live", lk_grab, 1); tick();
    // mixed traffic over a small address pool
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 2) == 0) req($urandom_range(0, 7), 32'h100 + $urandom_range(0, 5),
                                         $urandom_range(0, 3), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) begin rs_valid = 1; rs_tag = $urandom_range(0, 7); end
      if ($urandom_range(0, 3) == 0) begin
        st_valid = 1; st_tag = $urandom_range(0, 7); st_state = $urandom_range(0, 3);
      end
      if ($urandom_range(0, 1) == 0) look(32'h100 + $urandom_range(0, 5), $urandom_range(0, 1));
      tick();
    end
    @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule